// File: doc/BRIEF.md
# Hierarchical Weighted Memory-Request Arbiter

This block chooses which of several memory requesters is served next. The requesters are grouped into levels. Each level runs its own weighted rotation over its direct units plus one extra entry. That extra entry stands for every level beneath it. When a level's rotation lands on its extra entry, the decision passes down to the next level, which makes its own choice. A group of lower units therefore takes a single slot in its parent's sequence. Units that are idle or disabled are skipped, so their share falls through to the other entries in the same rotation and to the levels below.

Decisions are taken only when the memory controller pulses an arbitration-point strobe. The chosen unit's grant is registered one-hot and stays unchanged until the next strobe. Each entry has a weight. An owner that keeps requesting holds its entry for weight+1 consecutive decisions. An owner that stops requesting gives up the rest of its turn at once, because most requesters post one request and then wait for their data.

Top module: `hier_weighted_arb`

## Requirements
- R1: A synchronous active-high reset clears the grant to zero, sets every level's pointer to its first entry and clears every counter. The first decision after reset therefore picks the lowest-index eligible entry of level 0.
- R2: The grant changes only in the cycle after `arb_point` is high. At all other times it holds its value.
- R3: The grant has at most one bit set. Bit u belongs to unit u, and unit u sits on level u / PER_LVL at position u % PER_LVL.
- R4: A strobe taken while no unit has both its request and its enable bit high yields an all-zero grant.
- R5: A unit whose enable bit is low is never granted, whatever its request or weight.
- R6: Within a level the entries rotate in ascending position order, and the lower-level entry comes last. An entry with weight w (unit u's weight at `unit_wt[u*WT_W +: WT_W]`) is granted up to w+1 consecutive decisions while it keeps requesting.
- R7: An owner that has turns left but is not requesting at a strobe loses them. The next eligible entry after it is chosen.
- R8: With one enabled unit per level and all weights 0, level 0's unit takes every other decision, and the level-1 and level-2 units alternate in the remaining ones (50/25/25).
- R9: A level whose own units are all ineligible passes every decision that reaches it to the levels below. Units below are reached only through the lower-level entry.
- R10: The lower-level entry of level k uses the weight at `sub_wt[k*WT_W +: WT_W]`. Setting level 0's value to 1, with all other weights 0 and one unit per level, gives a repeating order of level-0 unit, level-1 unit, level-2 unit (one third each).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arb_point | input | 1 | One-cycle strobe from the memory controller marking a decision point |
| req | input | LEVELS*PER_LVL | Per-unit request lines |
| en | input | LEVELS*PER_LVL | Per-unit enable bits |
| unit_wt | input | LEVELS*PER_LVL*WT_W | Per-unit weights, WT_W bits each |
| sub_wt | input | LEVELS*WT_W | Weight of each level's lower-level entry |
| grant | output | LEVELS*PER_LVL | Registered one-hot grant, held between strobes |

## Verification
The bench builds the block with three levels of two units and 3-bit weights. With these values it can test rotation between two units on the same level and a weight large enough to produce several consecutive grants. It can also send a decision down two levels of the hierarchy. Using only the first unit of each level reproduces the 50/25/25 and one-third patterns exactly. Using only the bottom level's units shows decisions falling through two empty rotations.

// File: rtl/hwarb_pkg.sv
package hwarb_pkg;

  // Circular successor of an entry index within a rotation of n entries.
  function automatic int unsigned step_wrap(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Turns still owed to an entry after it is granted once more.
  function automatic int unsigned turns_left(bit keep_owner, int unsigned cnt,
                                             int unsigned wt);
    return keep_owner ? cnt - 1 : wt;
  endfunction

endpackage

// File: rtl/hwarb_pick.sv
module hwarb_pick #(
  parameter int N_ENT = 3,
  parameter int IDX_W = 2
) (
  input  logic [N_ENT-1:0] elig,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // First eligible entry at or after start, wrapping around.
  always_comb begin
    int c;
    found = 1'b0;
    idx   = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      c = int'(start) + k;
      if (c >= N_ENT) c = c - N_ENT;
      if (elig[c]) begin
        found = 1'b1;
        idx   = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/hwarb_level.sv
module hwarb_level
  import hwarb_pkg::*;
#(
  parameter int N_DIR = 2,
  parameter int WT_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               consult,
  input  logic [N_DIR-1:0]   dir_elig,
  input  logic               sub_elig,
  input  logic [N_DIR*WT_W-1:0] wt_dir,
  input  logic [WT_W-1:0]    wt_sub,
  output logic               level_any,
  output logic               pick_sub,
  output logic [N_DIR-1:0]   dir_gnt
);
  localparam int N_ENT = N_DIR + 1;
  localparam int IDX_W = $clog2(N_ENT);

  logic [IDX_W-1:0] ptr_q, start, pick_idx;
  logic [WT_W-1:0]  cnt_q, rem;
  logic [N_ENT-1:0] elig;
  logic [WT_W-1:0]  wt_ent [N_ENT];
  logic             found, upd, keep_owner, owner_gone;

  assign elig = {sub_elig, dir_elig};

  for (genvar i = 0; i < N_DIR; i++) begin : g_wt
    assign wt_ent[i] = wt_dir[i*WT_W +: WT_W];
  end
  assign wt_ent[N_DIR] = wt_sub;

  // An owner with turns left but no request forfeits them.
  assign owner_gone = (cnt_q != '0) && !elig[ptr_q];
  assign start = owner_gone ? IDX_W'(step_wrap(int'(ptr_q), N_ENT)) : ptr_q;

  hwarb_pick #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_pick (
    .elig  (elig),
    .start (start),
    .found (found),
    .idx   (pick_idx)
  );

  assign upd        = consult && found;
  assign keep_owner = (cnt_q != '0) && (pick_idx == ptr_q);
  assign rem = WT_W'(turns_left(keep_owner, int'(cnt_q), int'(wt_ent[pick_idx])));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      if (rem == '0) begin
        ptr_q <= IDX_W'(step_wrap(int'(pick_idx), N_ENT));
        cnt_q <= '0;
      end else begin
        ptr_q <= pick_idx;
        cnt_q <= rem;
      end
    end
  end

  assign level_any = found;
  assign pick_sub  = found && (pick_idx == IDX_W'(N_DIR));
  for (genvar i = 0; i < N_DIR; i++) begin : g_gnt
    assign dir_gnt[i] = upd && (pick_idx == IDX_W'(i));
  end

  // R9
  picked_is_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    upd |-> elig[pick_idx]);

  // R7
  owner_yields_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && owner_gone) |-> (pick_idx != ptr_q));

endmodule

// File: rtl/hier_weighted_arb.sv
module hier_weighted_arb #(
  parameter int LEVELS  = 3,
  parameter int PER_LVL = 2,
  parameter int WT_W    = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            arb_point,
  input  logic [LEVELS*PER_LVL-1:0]       req,
  input  logic [LEVELS*PER_LVL-1:0]       en,
  input  logic [LEVELS*PER_LVL*WT_W-1:0]  unit_wt,
  input  logic [LEVELS*WT_W-1:0]          sub_wt,
  output logic [LEVELS*PER_LVL-1:0]       grant
);
  localparam int UNITS = LEVELS * PER_LVL;

  logic [UNITS-1:0]  elig_u, grant_d, grant_q;
  logic [LEVELS-1:0] any_dir, below, consult, pick_sub, level_any;

  assign elig_u = req & en;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    assign any_dir[k] = |elig_u[k*PER_LVL +: PER_LVL];

    if (k == LEVELS - 1) begin : g_bottom
      assign below[k] = 1'b0;
    end else begin : g_mid
      assign below[k]     = below[k+1] | any_dir[k+1];
      assign consult[k+1] = consult[k] & pick_sub[k];
    end

    hwarb_level #(.N_DIR(PER_LVL), .WT_W(WT_W)) u_level (
      .clk       (clk),
      .rst       (rst),
      .consult   (consult[k]),
      .dir_elig  (elig_u[k*PER_LVL +: PER_LVL]),
      .sub_elig  (below[k]),
      .wt_dir    (unit_wt[k*PER_LVL*WT_W +: PER_LVL*WT_W]),
      .wt_sub    (sub_wt[k*WT_W +: WT_W]),
      .level_any (level_any[k]),
      .pick_sub  (pick_sub[k]),
      .dir_gnt   (grant_d[k*PER_LVL +: PER_LVL])
    );
  end

  assign consult[0] = arb_point;

  always_ff @(posedge clk) begin
    if (rst)            grant_q <= '0;
    else if (arb_point) grant_q <= grant_d;
  end

  assign grant = grant_q;

  // R3
  onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q));

  // R2
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !arb_point |=> $stable(grant_q));

  // R5
  grant_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    arb_point |=> ((grant_q & ~$past(elig_u)) == '0));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (arb_point && !level_any[0]) |=> (grant_q == '0));

endmodule

// File: tb/test_hier_weighted_arb.sv
module test_hier_weighted_arb;
  localparam int LV = 3, PL = 2, WW = 3, U = LV * PL;

  logic clk = 1'b0, rst = 1'b1, arb_point = 1'b0;
  logic [U-1:0]    req = '0, en = '0;
  logic [U*WW-1:0] unit_wt = '0;
  logic [LV*WW-1:0] sub_wt = '0;
  logic [U-1:0]    grant;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hier_weighted_arb #(.LEVELS(LV), .PER_LVL(PL), .WT_W(WW)) i_hier_weighted_arb (
    .clk(clk), .rst(rst), .arb_point(arb_point), .req(req), .en(en),
    .unit_wt(unit_wt), .sub_wt(sub_wt), .grant(grant)
  );

  task automatic chk(input string tag, input logic [U-1:0] act, input logic [U-1:0] exp);
    n_run++;
    if (act !== exp || $countones(act) > 1) begin
      n_fail++;
      $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [U-1:0] bit_of(input int u);
    return (u < 0) ? '0 : (U'(1) << u);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; arb_point = 1'b0; req = '0; en = '0; unit_wt = '0; sub_wt = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // One strobe, then compare the grant against the expected unit (-1: none).
  task automatic strobe_expect(input string tag, input int u);
    @(negedge clk); arb_point = 1'b1;
    @(negedge clk); arb_point = 1'b0;
    chk(tag, grant, bit_of(u));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset grant", grant, '0);
    req = 6'b000011; en = 6'b000011;
    strobe_expect("R1 first pick", 0);
  endtask

  task automatic t_hold();
    do_reset();
    req = 6'b000001; en = 6'b111111;
    strobe_expect("R2 grant", 0);
    req = 6'b000010;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 hold", grant, bit_of(0));
    end
  endtask

  task automatic t_default_share();
    do_reset();
    req = 6'b010101; en = 6'b010101;
    for (int i = 0; i < 2; i++) begin
      strobe_expect("R8 top", 0);
      strobe_expect("R8 mid", 2);
      strobe_expect("R8 top", 0);
      strobe_expect("R8 low", 4);
    end
  endtask

  task automatic t_thirds();
    do_reset();
    req = 6'b010101; en = 6'b010101;
    sub_wt[0 +: WW] = 3'd1;
    for (int i = 0; i < 2; i++) begin
      strobe_expect("R10 top", 0);
      strobe_expect("R10 mid", 2);
      strobe_expect("R10 low", 4);
    end
  endtask

  task automatic t_weighted();
    do_reset();
    req = 6'b000011; en = 6'b000011;
    unit_wt[0 +: WW] = 3'd2;
    for (int i = 0; i < 2; i++) begin
      strobe_expect("R6 run", 0);
      strobe_expect("R6 run", 0);
      strobe_expect("R6 run", 0);
      strobe_expect("R6 next", 1);
    end
  endtask

  task automatic t_yield();
    do_reset();
    req = 6'b000011; en = 6'b000011;
    unit_wt[0 +: WW] = 3'd3;
    strobe_expect("R7 owner", 0);
    req = 6'b000010;
    strobe_expect("R7 yield", 1);
    req = 6'b000011;
    strobe_expect("R7 back", 0);
  endtask

  task automatic t_disabled();
    do_reset();
    req = 6'b000011; en = 6'b000001;
    unit_wt[WW +: WW] = 3'd7;
    strobe_expect("R5 skip", 0);
    strobe_expect("R5 skip", 0);
    req = 6'b000010;
    strobe_expect("R5 off", -1);
  endtask

  task automatic t_idle();
    do_reset();
    req = 6'b000100; en = 6'b111111;
    strobe_expect("R4 before", 2);
    req = '0;
    strobe_expect("R4 idle", -1);
  endtask

  task automatic t_fall();
    do_reset();
    req = 6'b100100; en = 6'b111111;
    strobe_expect("R9 mid", 2);
    strobe_expect("R9 low", 5);
    strobe_expect("R9 mid", 2);
    strobe_expect("R9 low", 5);
    req = 6'b100000;
    strobe_expect("R9 deep", 5);
    strobe_expect("R9 deep", 5);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_default_share();
    t_thirds();
    t_weighted();
    t_yield();
    t_disabled();
    t_idle();
    t_fall();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule